// File: doc/BRIEF.md
# DRAM ECC Error Status and Capture Unit

This unit collects error reports from one or two per-channel DRAM ECC checkers and keeps them for software. A checker raises a one-cycle correctable or uncorrectable pulse along with the column, row, bank, rank and syndrome of the failing access. The unit then sets a sticky flag in a shared 16-bit status word and records the event in that channel's 64-bit capture log. Software polls the status word. It reads each log as two separate 32-bit halves, low half first, and clears the flags by writing ones to them. Clearing a flag also re-arms capture in every channel log.

Each log keeps the first correctable error it sees. An uncorrectable error replaces a held correctable record, because it is the more important event. Once an uncorrectable record is held, nothing replaces it until software clears it. A strap input selects single-channel operation. In that mode the second channel's reports are dropped and its log reads as zero.

Top module: `ecc_err_logger`

## Requirements
- R1: After a synchronous reset the status word, both capture logs and `reg_rvalid` are zero.
- R2: A correctable pulse on an active channel whose log holds nothing records column, row, bank, rank and syndrome, and sets log bit 0. It also sets status bit 0.
- R3: An uncorrectable pulse on an active channel records column, row, bank and rank, with the syndrome field forced to zero, and sets log bit 1. It also sets status bit 1. If both pulses arrive in the same cycle, the uncorrectable one is recorded.
- R4: A correctable pulse arriving while the channel log already holds a correctable record leaves the log unchanged.
- R5: An uncorrectable pulse arriving while the log holds a correctable record replaces it: new fields, syndrome zero, log bit 1 set and log bit 0 cleared. The status word then shows both bits 0 and 1.
- R6: While a log holds an uncorrectable record, further pulses of either kind on that channel leave the log unchanged.
- R7: Writing the status word clears each of bits 1:0 that is written as 1, and leaves alone each bit written as 0. The same write clears the matching valid bit (bit 0 or bit 1) in every channel log. Captured fields keep their values, and capture is re-armed.
- R8: When a clearing write and a new pulse of the same kind arrive in the same cycle, the flag stays set. The log captures the new event as if it had been empty.
- R9: With `single_ch` high, channel 1 pulses affect neither the status word nor the channel 1 log, and both channel 1 log halves read as zero.
- R10: Byte address map: the status word is at 0x00C8, in bits 15:0, with bits 31:2 reading zero. Channel c's low half is at 0x40C8 + 0x400*c and its high half is 4 bytes above. Low half: bits 31:29 bank, 28:27 rank, 23:16 syndrome, bit 1 uncorrectable, bit 0 correctable, all other bits zero. High half: bits 31:16 column, 15:0 row. Any other address, including a misaligned one, reads zero. Writes anywhere but the status word have no effect.
- R11: A read strobe produces `reg_rvalid` with the data exactly one cycle later. Without a strobe, `reg_rvalid` and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_ch | input | 1 | 1 = only channel 0 is active |
| err_ce | input | NUM_CH | Per-channel correctable error pulse |
| err_ue | input | NUM_CH | Per-channel uncorrectable error pulse |
| err_col | input | NUM_CH*16 | Per-channel column of the failing access |
| err_row | input | NUM_CH*16 | Per-channel row |
| err_bank | input | NUM_CH*3 | Per-channel bank |
| err_rank | input | NUM_CH*2 | Per-channel rank |
| err_synd | input | NUM_CH*8 | Per-channel ECC syndrome |
| reg_addr | input | 16 | Register byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| reg_rdata | output | 32 | Read data |

## Verification
The bench concentrates on the priority between correctable and uncorrectable records. It checks that a second correctable event is dropped, that an uncorrectable event replaces a correctable one, and that nothing replaces an uncorrectable record. A design with the wrong priority would return the later fields, or a non-zero syndrome, in the low half. The bench also drives a clearing write in the same cycle as a new event. A design that lets the clear win would drop the flag and lose the record. Single-channel mode is checked both while it is active, when channel 1 must read zero, and after it is released, when the channel 1 log must still hold its earlier record. Misaligned and unmapped reads, and writes to log addresses, are checked to return zero or to change nothing.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
package ecc_log_pkg;
    localparam int COL_W  = 16;
    localparam int ROW_W  = 16;
    localparam int BANK_W = 3;
    localparam int RANK_W = 2;
    localparam int SYND_W = 8;
    localparam int DW     = 32;
    localparam int AW     = 16;
    localparam int STS_W  = 16;
    localparam int FLAG_CE = 0;
    localparam int FLAG_UE = 1;

    // fields reported by a channel checker with a pulse
    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [RANK_W-1:0] rank;
        logic [SYND_W-1:0] synd;
    } evt_t;

    // one channel capture record
    typedef struct packed {
        evt_t f;
        logic ue;
        logic ce;
    } log_t;

    function automatic logic [DW-1:0] log_lo(input log_t l);
        return {l.f.bank, l.f.rank, 3'b000, l.f.synd, 14'b0, l.ue, l.ce};
    endfunction

    function automatic logic [DW-1:0] log_hi(input log_t l);
        return {l.f.col, l.f.row};
    endfunction
endpackage

// File: rtl/ecc_chan_log.sv
`timescale 1ns/1ps
module ecc_chan_log
    import ecc_log_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic ce,
    input  logic ue,
    input  evt_t evt,
    input  logic clr_ce,
    input  logic clr_ue,
    output log_t q
);
    log_t d;
    logic ce_held, ue_held, cap_ue, cap_ce;

    always_comb begin
        // clear first, then decide capture on the re-armed state
        ce_held = q.ce & ~clr_ce;
        ue_held = q.ue & ~clr_ue;
        cap_ue  = active & ue & ~ue_held;
        cap_ce  = active & ce & ~ue & ~ce_held & ~ue_held;
        d       = q;
        d.ce    = ce_held;
        d.ue    = ue_held;
        if (cap_ue) begin
            d.f      = evt;
            d.f.synd = '0;
            d.ue     = 1'b1;
            d.ce     = 1'b0;
        end else if (cap_ce) begin
            d.f  = evt;
            d.ce = 1'b1;
            d.ue = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/ecc_sts_reg.sv
`timescale 1ns/1ps
module ecc_sts_reg
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       set_flag,
    input  logic [1:0]       clr_flag,
    output logic [STS_W-1:0] sts
);
    logic [1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~clr_flag) | set_flag;
    end

    assign sts = {{(STS_W-2){1'b0}}, flag_q};
endmodule

// File: rtl/ecc_reg_rd.sv
`timescale 1ns/1ps
module ecc_reg_rd
    import ecc_log_pkg::*;
#(
    parameter int          NUM_CH    = 2,
    parameter int unsigned STS_ADDR  = 32'h00C8,
    parameter int unsigned LOG_BASE  = 32'h40C8,
    parameter int unsigned CH_STRIDE = 32'h0400
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [STS_W-1:0]    sts,
    input  log_t [NUM_CH-1:0]   logs,
    input  logic [NUM_CH-1:0]   ch_active,
    output logic                rvalid,
    output logic [DW-1:0]       rdata
);
    function automatic logic [AW-1:0] lo_at(input int c);
        return AW'(LOG_BASE + CH_STRIDE * c);
    endfunction

    logic [DW-1:0] val;

    always_comb begin
        val = '0;
        if (addr == AW'(STS_ADDR)) val = {{(DW-STS_W){1'b0}}, sts};
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_active[c] && addr == lo_at(c))         val = log_lo(logs[c]);
            if (ch_active[c] && addr == lo_at(c) + AW'(4)) val = log_hi(logs[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? val : '0;
        end
    end
endmodule

// File: rtl/ecc_err_logger.sv
`timescale 1ns/1ps
module ecc_err_logger
    import ecc_log_pkg::*;
#(
    parameter int          NUM_CH    = 2,
    parameter int unsigned STS_ADDR  = 32'h00C8,
    parameter int unsigned LOG_BASE  = 32'h40C8,
    parameter int unsigned CH_STRIDE = 32'h0400
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     single_ch,
    input  logic [NUM_CH-1:0]        err_ce,
    input  logic [NUM_CH-1:0]        err_ue,
    input  logic [NUM_CH*COL_W-1:0]  err_col,
    input  logic [NUM_CH*ROW_W-1:0]  err_row,
    input  logic [NUM_CH*BANK_W-1:0] err_bank,
    input  logic [NUM_CH*RANK_W-1:0] err_rank,
    input  logic [NUM_CH*SYND_W-1:0] err_synd,
    input  logic [AW-1:0]            reg_addr,
    input  logic                     reg_wr_en,
    input  logic [DW-1:0]            reg_wdata,
    input  logic                     reg_rd_en,
    output logic                     reg_rvalid,
    output logic [DW-1:0]            reg_rdata
);
    logic [NUM_CH-1:0] ch_active, ce_act, ue_act;
    log_t [NUM_CH-1:0] log_q;
    logic [1:0]        clr_flag;
    logic [STS_W-1:0]  sts_word;

    assign clr_flag = (reg_wr_en && reg_addr == AW'(STS_ADDR)) ? reg_wdata[1:0] : 2'b00;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        evt_t evt;
        if (c == 0) begin : g_primary
            assign ch_active[c] = 1'b1;
        end else begin : g_secondary
            assign ch_active[c] = ~single_ch;
        end
        assign ce_act[c] = err_ce[c] & ch_active[c];
        assign ue_act[c] = err_ue[c] & ch_active[c];
        assign evt = '{col:  err_col [c*COL_W  +: COL_W],
                       row:  err_row [c*ROW_W  +: ROW_W],
                       bank: err_bank[c*BANK_W +: BANK_W],
                       rank: err_rank[c*RANK_W +: RANK_W],
                       synd: err_synd[c*SYND_W +: SYND_W]};

        ecc_chan_log u_log (
            .clk    (clk),
            .rst    (rst),
            .active (ch_active[c]),
            .ce     (err_ce[c]),
            .ue     (err_ue[c]),
            .evt    (evt),
            .clr_ce (clr_flag[FLAG_CE]),
            .clr_ue (clr_flag[FLAG_UE]),
            .q      (log_q[c])
        );
    end

    ecc_sts_reg u_sts (
        .clk      (clk),
        .rst      (rst),
        .set_flag ({|ue_act, |ce_act}),
        .clr_flag (clr_flag),
        .sts      (sts_word)
    );

    ecc_reg_rd #(
        .NUM_CH    (NUM_CH),
        .STS_ADDR  (STS_ADDR),
        .LOG_BASE  (LOG_BASE),
        .CH_STRIDE (CH_STRIDE)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (reg_rd_en),
        .addr      (reg_addr),
        .sts       (sts_word),
        .logs      (log_q),
        .ch_active (ch_active),
        .rvalid    (reg_rvalid),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/ecc_err_logger_chk.sv
`timescale 1ns/1ps
module ecc_err_logger_chk #(
    parameter int unsigned STS_ADDR = 32'h00C8
)(
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        wr_en,
    input logic [15:0] addr,
    input logic [31:0] wdata,
    input logic        rvalid,
    input logic [31:0] rdata,
    input logic        ce0,
    input logic        ue0,
    input logic [1:0]  flags,
    input logic        log0_ce,
    input logic        log0_ue
);
    logic clr_ue_wr;
    assign clr_ue_wr = wr_en && addr == 16'(STS_ADDR) && wdata[1];

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst) rd_en |=> rvalid); // R11
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst) !rd_en |=> (!rvalid && rdata == '0)); // R11
    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && addr[1:0] != 2'b00) |=> rdata == '0); // R10
    AST_CE_FLAG_SET: assert property (@(posedge clk) disable iff (rst) ce0 |=> flags[0]); // R8
    AST_UE_FLAG_SET: assert property (@(posedge clk) disable iff (rst) ue0 |=> flags[1]); // R3
    AST_UE_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (flags[1] && !clr_ue_wr) |=> flags[1]); // R7
    AST_UE_LOG_HOLDS: assert property (@(posedge clk) disable iff (rst) (log0_ue && !clr_ue_wr) |=> (log0_ue && !log0_ce)); // R6
    AST_LOG_ONE_KIND: assert property (@(posedge clk) disable iff (rst) $onehot0({log0_ue, log0_ce})); // R5
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.STS_ADDR(STS_ADDR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (reg_rd_en),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rvalid  (reg_rvalid),
    .rdata   (reg_rdata),
    .ce0     (err_ce[0]),
    .ue0     (err_ue[0]),
    .flags   (sts_word[1:0]),
    .log0_ce (log_q[0].ce),
    .log0_ue (log_q[0].ue)
);

// File: tb/test_ecc_err_logger.sv
`timescale 1ns/1ps
module test_ecc_err_logger;
    localparam logic [15:0] A_STS = 16'h00C8;
    localparam logic [15:0] A_LO0 = 16'h40C8, A_HI0 = 16'h40CC;
    localparam logic [15:0] A_LO1 = 16'h44C8, A_HI1 = 16'h44CC;

    logic        clk = 0, rst = 1, single_ch = 0;
    logic [1:0]  err_ce = 0, err_ue = 0;
    logic [31:0] err_col = 0, err_row = 0;
    logic [5:0]  err_bank = 0;
    logic [3:0]  err_rank = 0;
    logic [15:0] err_synd = 0;
    logic [15:0] reg_addr = 0;
    logic        reg_wr_en = 0, reg_rd_en = 0, reg_rvalid;
    logic [31:0] reg_wdata = 0, reg_rdata;

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    ecc_err_logger i_ecc_err_logger (.*);

    function automatic logic [31:0] lo(input logic [2:0] b, input logic [1:0] r,
                                       input logic [7:0] s, input logic ue, input logic ce);
        return {b, r, 3'b000, s, 14'b0, ue, ce};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (!rst && reg_rvalid) begin
            if (exp_q.size() == 0) check("R11 unexpected rvalid", 32'd1, 32'd0);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd_en = 1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd_en = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic set_evt(input int c, input logic ce, input logic ue, input logic [15:0] col,
                           input logic [15:0] row, input logic [2:0] b, input logic [1:0] r,
                           input logic [7:0] s);
        err_ce[c] = ce; err_ue[c] = ue;
        err_col[c*16 +: 16] = col; err_row[c*16 +: 16] = row;
        err_bank[c*3 +: 3] = b; err_rank[c*2 +: 2] = r; err_synd[c*8 +: 8] = s;
    endtask

    task automatic pulse(input int c, input logic ce, input logic ue, input logic [15:0] col,
                         input logic [15:0] row, input logic [2:0] b, input logic [1:0] r,
                         input logic [7:0] s);
        @(negedge clk);
        set_evt(c, ce, ue, col, row, b, r, s);
        @(negedge clk);
        err_ce = 0; err_ue = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 rvalid after reset", {31'b0, reg_rvalid}, 32'd0);
        rd(A_STS, 32'd0, "R1 status reset");
        rd(A_LO0, 32'd0, "R1 log0 reset");
        rd(A_HI1, 32'd0, "R1 log1 reset");

        pulse(0, 1, 0, 16'h1111, 16'h2222, 3'd5, 2'd2, 8'hA5);
        rd(A_STS, 32'd1, "R2 status CE");
        rd(A_LO0, lo(5, 2, 8'hA5, 0, 1), "R2 log0 low");
        rd(A_HI0, 32'h1111_2222, "R2 log0 high");

        pulse(0, 1, 0, 16'h9999, 16'h8888, 3'd1, 2'd3, 8'h11);
        rd(A_LO0, lo(5, 2, 8'hA5, 0, 1), "R4 second CE dropped");
        rd(A_HI0, 32'h1111_2222, "R4 second CE dropped high");

        pulse(0, 0, 1, 16'h3333, 16'h4444, 3'd3, 2'd1, 8'h77);
        rd(A_STS, 32'd3, "R5 status both");
        rd(A_LO0, lo(3, 1, 8'h00, 1, 0), "R5 UE overwrites CE");
        rd(A_HI0, 32'h3333_4444, "R5 UE overwrite high");

        pulse(0, 1, 0, 16'h0001, 16'h0002, 3'd2, 2'd2, 8'h22);
        pulse(0, 0, 1, 16'h0003, 16'h0004, 3'd4, 2'd0, 8'h33);
        rd(A_LO0, lo(3, 1, 8'h00, 1, 0), "R6 UE log held");
        rd(A_HI0, 32'h3333_4444, "R6 UE log held high");

        wr(A_STS, 32'd0);
        rd(A_STS, 32'd3, "R7 write zero keeps");
        wr(A_STS, 32'd1);
        rd(A_STS, 32'd2, "R7 clear CE only");
        wr(A_STS, 32'd2);
        rd(A_STS, 32'd0, "R7 clear UE");
        rd(A_LO0, lo(3, 1, 8'h00, 0, 0), "R7 log bits cleared");

        pulse(1, 1, 0, 16'hAAAA, 16'hBBBB, 3'd6, 2'd3, 8'h3C);
        rd(A_LO1, lo(6, 3, 8'h3C, 0, 1), "R2 log1 low");
        rd(A_HI1, 32'hAAAA_BBBB, "R2 log1 high");

        // clear CE in the same cycle as a new CE on channel 0
        @(negedge clk);
        reg_addr = A_STS; reg_wdata = 32'd1; reg_wr_en = 1;
        set_evt(0, 1, 0, 16'h1234, 16'h5678, 3'd2, 2'd0, 8'hC3);
        @(negedge clk);
        reg_wr_en = 0; err_ce = 0;
        rd(A_STS, 32'd1, "R8 flag survives clear");
        rd(A_LO0, lo(2, 0, 8'hC3, 0, 1), "R8 new CE captured");
        rd(A_LO1, lo(6, 3, 8'h3C, 0, 0), "R7 log1 CE cleared");

        wr(A_STS, 32'd3);
        pulse(0, 1, 1, 16'h0F0F, 16'hF0F0, 3'd7, 2'd2, 8'h99);
        rd(A_STS, 32'd3, "R3 both flags");
        rd(A_LO0, lo(7, 2, 8'h00, 1, 0), "R3 UE wins same cycle");
        rd(A_HI0, 32'h0F0F_F0F0, "R3 UE high");

        wr(A_STS, 32'hFFFF_FFFF);
        single_ch = 1;
        pulse(1, 1, 0, 16'h0001, 16'h0002, 3'd1, 2'd1, 8'h55);
        pulse(1, 0, 1, 16'h0005, 16'h0006, 3'd2, 2'd2, 8'h66);
        rd(A_STS, 32'd0, "R9 ch1 ignored status");
        rd(A_LO1, 32'd0, "R9 ch1 low reads zero");
        rd(A_HI1, 32'd0, "R9 ch1 high reads zero");
        single_ch = 0;
        rd(A_LO1, lo(6, 3, 8'h3C, 0, 0), "R9 ch1 log untouched");
        pulse(1, 0, 1, 16'h4321, 16'h8765, 3'd4, 2'd3, 8'hEE);
        rd(A_STS, 32'd2, "R3 ch1 UE status");
        rd(A_LO1, lo(4, 3, 8'h00, 1, 0), "R3 ch1 UE low");
        rd(A_HI1, 32'h4321_8765, "R3 ch1 UE high");

        wr(A_LO1, 32'hFFFF_FFFF);
        rd(A_LO1, lo(4, 3, 8'h00, 1, 0), "R10 log write ignored");
        rd(16'h0000, 32'd0, "R10 unmapped");
        rd(16'h40CA, 32'd0, "R10 misaligned");
        rd(16'h00CC, 32'd0, "R10 next to status");

        repeat (3) @(negedge clk);
        check("R11 all reads returned", exp_q.size(), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule